// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block is the interrupt-status section of a FIFO-based UART. It takes seven pending conditions: line-status error, receive data at trigger level, receive timeout, transmit holding register empty, modem-status change, flow-control character (Xoff or special character), and CTS/RTS change. It gates each condition with its enable bit and reports only the most urgent enabled one as a six-bit code in the low bits of a status byte. It also drives an active-high interrupt line.

Event-type sources are held in sticky flags until their clearing action occurs. The receive-data source follows the FIFO trigger comparison directly. The receive timeout source comes from a built-in counter of character-time ticks. The register bus decode lives outside this block. A read of a register reaches the block only as a one-cycle strobe.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, no source is pending. With FIFOs disabled the status byte reads 0x01 and `irq_o` is 0.
- R2: Status bit 0 is 1 when nothing enabled is pending and 0 otherwise. `irq_o` is high exactly when bit 0 is 0.
- R3: Status bits 5:0 carry these codes: line status 000110, receive data 000100, receive timeout 001100, transmit empty 000010, modem status 000000, Xoff/special 010000, CTS/RTS change 100000. Only one code is shown at a time. Priority from highest to lowest is: line status, receive data/timeout, transmit empty, modem status, Xoff/special, CTS/RTS change.
- R4: A pulse on `isr_rd_i` clears the reported source, one clock later, when that source is transmit empty, timeout, Xoff/special or CTS/RTS change. The next lower pending source then shows. Other pending sources are left untouched.
- R5: With the receive FIFO not empty, the timeout source becomes pending on the clock of the TO_CHARS-th (default 4) `char_tick_i` pulse with no restart in between. It never becomes pending while `rx_empty_i` is 1.
- R6: A `stop_ctr_i` pulse or an `rhr_rd_i` pulse restarts the timeout count and clears a pending timeout.
- R7: The receive-data source is pending exactly while `rx_trig_i` is 1. It drops in the same cycle that the FIFO level falls below trigger.
- R8: The Xoff/special source and the CTS/RTS source are reported only while `enh_en_i` is 1.
- R9: Status bits 7:6 are both 1 when `fifo_en_i` is 1, and both 0 otherwise.
- R10: `thr_wr_i` clears the transmit-empty source. `lsr_rd_i` clears line status. `msr_rd_i` clears modem status. A status read does not clear line status or modem status.
- R11: Enable mapping is: `ien_i[2]` line status, `ien_i[0]` receive data and timeout, `ien_i[1]` transmit empty, `ien_i[3]` modem, `ien_i[5]` Xoff/special, and `ien_i[6]` or `ien_i[7]` CTS/RTS. A disabled source is not reported, but its sticky flag stays set and is reported once enabled.
- R12: When receive data and timeout are both pending and enabled, receive data is the code shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low |
| ien_i | input | 8 | Interrupt enable bits |
| enh_en_i | input | 1 | Enhanced-feature enable for the flow-control sources |
| fifo_en_i | input | 1 | FIFOs enabled; drives status bits 7:6 |
| ls_evt_i | input | 1 | Line-status error event pulse |
| rx_trig_i | input | 1 | Receive FIFO level at or above trigger |
| rx_empty_i | input | 1 | Receive FIFO empty |
| stop_ctr_i | input | 1 | Centre of a received stop bit |
| char_tick_i | input | 1 | One-character-time tick |
| thr_evt_i | input | 1 | Transmit holding register became empty |
| ms_evt_i | input | 1 | Modem input change event |
| xoff_evt_i | input | 1 | Xoff or special character received |
| fc_evt_i | input | 1 | CTS/RTS change event |
| isr_rd_i | input | 1 | Status register read strobe |
| rhr_rd_i | input | 1 | Receive holding register read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| isr_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Every event, tick and read strobe is captured by a register on one rising edge. The status byte is then combinational from those registers, so an effect is due one clock after its strobe. The bench drives each strobe for one cycle from a falling edge and samples on the next falling edge, which is half a period after that capture. Changes on `rx_trig_i`, `fifo_en_i`, `ien_i` and `enh_en_i` pass through combinationally, so they are checked on the falling edge right after they are driven. The timeout is checked both one tick short of its limit and on the tick that reaches it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // source slots, listed from highest to lowest priority
  localparam int NSRC   = 7;
  localparam int S_LS   = 0;
  localparam int S_RXD  = 1;
  localparam int S_TO   = 2;
  localparam int S_THR  = 3;
  localparam int S_MS   = 4;
  localparam int S_XOFF = 5;
  localparam int S_FC   = 6;

  // sticky flag slots inside the flag bank
  localparam int NSTICKY = 5;
  localparam int F_LS    = 0;
  localparam int F_THR   = 1;
  localparam int F_MS    = 2;
  localparam int F_XOFF  = 3;
  localparam int F_FC    = 4;

  localparam logic [5:0] C_LS   = 6'b000110;
  localparam logic [5:0] C_RXD  = 6'b000100;
  localparam logic [5:0] C_TO   = 6'b001100;
  localparam logic [5:0] C_THR  = 6'b000010;
  localparam logic [5:0] C_MS   = 6'b000000;
  localparam logic [5:0] C_XOFF = 6'b010000;
  localparam logic [5:0] C_FC   = 6'b100000;
  localparam logic [5:0] C_NONE = 6'b000001;

  function automatic logic [5:0] src_code(input int idx);
    case (idx)
      S_LS:    return C_LS;
      S_RXD:   return C_RXD;
      S_TO:    return C_TO;
      S_THR:   return C_THR;
      S_MS:    return C_MS;
      S_XOFF:  return C_XOFF;
      S_FC:    return C_FC;
      default: return C_NONE;
    endcase
  endfunction

  // walk upward from the lowest slot so the highest pending slot wins
  function automatic logic [5:0] winner_code(input logic [NSRC-1:0] eff);
    logic [5:0] c;
    c = C_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (eff[i]) c = src_code(i);
    end
    return c;
  endfunction

  function automatic logic [NSRC-1:0] enable_map(input logic [7:0] ien,
                                                 input logic enh);
    logic [NSRC-1:0] en;
    en         = '0;
    en[S_LS]   = ien[2];
    en[S_RXD]  = ien[0];
    en[S_TO]   = ien[0];
    en[S_THR]  = ien[1];
    en[S_MS]   = ien[3];
    en[S_XOFF] = ien[5] & enh;
    en[S_FC]   = (ien[6] | ien[7]) & enh;
    return en;
  endfunction

endpackage

// File: rtl/irq_pend_flags.sv
module irq_pend_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign pend_o[g] = q;

    AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_o[g]); // R11
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]); // R4
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !set_i[g]) |=> $stable(pend_o[g])); // R10
  end

endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
  parameter int TO_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_empty_i,
  input  logic stop_ctr_i,
  input  logic rhr_rd_i,
  input  logic char_tick_i,
  input  logic clr_i,
  output logic to_pend_o
);

  localparam int CW = $clog2(TO_CHARS + 1);
  localparam logic [CW-1:0] LAST = CW'(TO_CHARS - 1);

  logic [CW-1:0] cnt_q;
  logic          to_q;
  logic          restart;
  logic          advance;
  logic          hit_limit;

  assign restart   = rx_empty_i | stop_ctr_i | rhr_rd_i | clr_i;
  assign advance   = char_tick_i & ~to_q & ~restart;
  assign hit_limit = advance & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (advance) begin
      cnt_q <= cnt_q + 1'b1;
      if (hit_limit) to_q <= 1'b1;
    end
  end

  assign to_pend_o = to_q;

  AST_TO_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty_i |=> !to_pend_o); // R5
  AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ctr_i || rhr_rd_i) |=> (cnt_q == '0 && !to_pend_o)); // R6
  AST_TO_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    hit_limit |=> to_pend_o); // R5
  AST_TO_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_pend_o && !hit_limit) |=> !to_pend_o); // R5

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic [7:0]      ien_i,
  input  logic            enh_en_i,
  output logic [NSRC-1:0] eff_o,
  output logic [5:0]      code_o,
  output logic            any_o
);

  always_comb begin
    eff_o  = pend_i & enable_map(ien_i, enh_en_i);
    code_o = winner_code(eff_o);
    any_o  = |eff_o;
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ien_i,
  input  logic       enh_en_i,
  input  logic       fifo_en_i,
  input  logic       ls_evt_i,
  input  logic       rx_trig_i,
  input  logic       rx_empty_i,
  input  logic       stop_ctr_i,
  input  logic       char_tick_i,
  input  logic       thr_evt_i,
  input  logic       ms_evt_i,
  input  logic       xoff_evt_i,
  input  logic       fc_evt_i,
  input  logic       isr_rd_i,
  input  logic       rhr_rd_i,
  input  logic       lsr_rd_i,
  input  logic       msr_rd_i,
  input  logic       thr_wr_i,
  output logic [7:0] isr_o,
  output logic       irq_o
);

  logic [NSTICKY-1:0] flag_set;
  logic [NSTICKY-1:0] flag_clr;
  logic [NSTICKY-1:0] flag_q;
  logic [NSRC-1:0]    pend;
  logic [NSRC-1:0]    eff;
  logic [5:0]         code;
  logic               any_pend;
  logic               to_pend;
  logic               to_clr;

  // reported-source read hits, brought out for the assertions
  logic rd_hit_thr, rd_hit_to, rd_hit_xoff, rd_hit_fc;
  assign rd_hit_thr  = isr_rd_i & (code == C_THR);
  assign rd_hit_to   = isr_rd_i & (code == C_TO);
  assign rd_hit_xoff = isr_rd_i & (code == C_XOFF);
  assign rd_hit_fc   = isr_rd_i & (code == C_FC);
  assign to_clr      = rd_hit_to;

  always_comb begin
    flag_set         = '0;
    flag_set[F_LS]   = ls_evt_i;
    flag_set[F_THR]  = thr_evt_i;
    flag_set[F_MS]   = ms_evt_i;
    flag_set[F_XOFF] = xoff_evt_i;
    flag_set[F_FC]   = fc_evt_i;
    flag_clr         = '0;
    flag_clr[F_LS]   = lsr_rd_i;
    flag_clr[F_THR]  = thr_wr_i | rd_hit_thr;
    flag_clr[F_MS]   = msr_rd_i;
    flag_clr[F_XOFF] = rd_hit_xoff;
    flag_clr[F_FC]   = rd_hit_fc;
  end

  irq_pend_flags #(.N(NSTICKY)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .pend_o (flag_q)
  );

  irq_rx_timeout #(.TO_CHARS(TO_CHARS)) u_timeout (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_empty_i  (rx_empty_i),
    .stop_ctr_i  (stop_ctr_i),
    .rhr_rd_i    (rhr_rd_i),
    .char_tick_i (char_tick_i),
    .clr_i       (to_clr),
    .to_pend_o   (to_pend)
  );

  always_comb begin
    pend         = '0;
    pend[S_LS]   = flag_q[F_LS];
    pend[S_RXD]  = rx_trig_i;
    pend[S_TO]   = to_pend;
    pend[S_THR]  = flag_q[F_THR];
    pend[S_MS]   = flag_q[F_MS];
    pend[S_XOFF] = flag_q[F_XOFF];
    pend[S_FC]   = flag_q[F_FC];
  end

  irq_prio_enc u_enc (
    .pend_i   (pend),
    .ien_i    (ien_i),
    .enh_en_i (enh_en_i),
    .eff_o    (eff),
    .code_o   (code),
    .any_o    (any_pend)
  );

  assign isr_o = {{2{fifo_en_i}}, code};
  assign irq_o = any_pend;

  AST_INT_VS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !isr_o[0]); // R2
  AST_LS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    eff[S_LS] |-> isr_o[5:0] == C_LS); // R3
  AST_RXD_OVER_TO: assert property (@(posedge clk) disable iff (!rst_n)
    (eff[S_RXD] && !eff[S_LS]) |-> isr_o[5:0] == C_RXD); // R12
  AST_FLOW_NEEDS_ENH: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en_i |-> isr_o[5:4] == 2'b00); // R8
  AST_RD_SPARES_LS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[F_LS] && isr_rd_i && !lsr_rd_i) |=> flag_q[F_LS]); // R10
  AST_THR_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit_thr && !thr_evt_i) |=> !flag_q[F_THR]); // R4

endmodule

// File: tb/uart_irq_prio_tb_top.sv
module uart_irq_prio_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ien = '0;
  logic       enh = 0, fifo = 0, ls = 0, rxtrig = 0, rxempty = 1, stopc = 0;
  logic       tick = 0, thr = 0, ms = 0, xoff = 0, fc = 0;
  logic       isr_rd = 0, rhr_rd = 0, lsr_rd = 0, msr_rd = 0, thr_wr = 0;
  logic [7:0] isr;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  uart_irq_prio #(.TO_CHARS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ien_i(ien), .enh_en_i(enh), .fifo_en_i(fifo),
    .ls_evt_i(ls), .rx_trig_i(rxtrig), .rx_empty_i(rxempty),
    .stop_ctr_i(stopc), .char_tick_i(tick), .thr_evt_i(thr), .ms_evt_i(ms),
    .xoff_evt_i(xoff), .fc_evt_i(fc), .isr_rd_i(isr_rd), .rhr_rd_i(rhr_rd),
    .lsr_rd_i(lsr_rd), .msr_rd_i(msr_rd), .thr_wr_i(thr_wr),
    .isr_o(isr), .irq_o(irq)
  );

  // {ien, enh, fifo, ls, thr, ms, xoff, fc, rxtrig, expected status}
  localparam logic [23:0] VEC [16] = '{
    24'hFF_FF_C6, 24'hFF_9F_04, 24'hFF_DE_C2, 24'hFF_CE_C0,
    24'hFF_C6_D0, 24'hFF_C2_E0, 24'hFF_42_C1, 24'hFF_04_01,
    24'h00_FF_C1, 24'h02_BF_02, 24'h08_BF_00, 24'h40_92_20,
    24'h80_82_20, 24'h04_21_06, 24'h01_41_C4, 24'hFF_91_04
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (isr !== exp || irq !== !exp[0]) begin
      n_bad++;
      $display("FAIL %s: status=%02h irq=%0b expected status=%02h irq=%0b",
               req, isr, irq, exp, !exp[0]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic pulse_tick(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
    end
  endtask

  task automatic read_isr();
    isr_rd = 1'b1;
    step();
    isr_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step();
    do_reset();
    step();
    check("R1 reset state", 8'h01);

    // vector walk: R3 R8 R9 R11 R12 and R2 on every line
    for (int v = 0; v < 16; v++) begin
      do_reset();
      ien = VEC[v][23:16]; enh = VEC[v][15]; fifo = VEC[v][14];
      ls = VEC[v][13]; thr = VEC[v][12]; ms = VEC[v][11];
      xoff = VEC[v][10]; fc = VEC[v][9]; rxtrig = VEC[v][8];
      step();
      {ls, thr, ms, xoff, fc} = '0;
      check($sformatf("R3 R8 R9 R11 vector %0d", v), VEC[v][7:0]);
      rxtrig = 1'b0;
    end

    // R4: status read peels off the reported source only
    do_reset();
    ien = 8'hFF; enh = 1'b1; fifo = 1'b0;
    thr = 1'b1; xoff = 1'b1; fc = 1'b1;
    step();
    {thr, xoff, fc} = '0;
    check("R4 first", 8'h02);
    read_isr();
    check("R4 after thr read", 8'h10);
    read_isr();
    check("R4 after xoff read", 8'h20);
    read_isr();
    check("R4 after fc read", 8'h01);

    // R10: modem and line status survive a status read
    ms = 1'b1; step(); ms = 1'b0;
    check("R10 modem set", 8'h00);
    read_isr();
    check("R10 modem kept on status read", 8'h00);
    msr_rd = 1'b1; step(); msr_rd = 1'b0;
    check("R10 modem cleared by msr read", 8'h01);
    ls = 1'b1; step(); ls = 1'b0;
    read_isr();
    check("R10 line status kept on status read", 8'h06);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    check("R10 line status cleared", 8'h01);
    thr = 1'b1; step(); thr = 1'b0;
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    check("R10 thr write clears", 8'h01);

    // R11: masked sticky source shows once enabled
    ien = 8'h00; thr = 1'b1; step(); thr = 1'b0;
    check("R11 masked", 8'h01);
    ien = 8'h02; step();
    check("R11 unmasked later", 8'h02);
    thr_wr = 1'b1; step(); thr_wr = 1'b0;

    // R7: receive data follows the trigger comparison
    ien = 8'h01; rxtrig = 1'b1; step();
    check("R7 at trigger", 8'h04);
    rxtrig = 1'b0; step();
    check("R7 below trigger", 8'h01);

    // R5: timeout after four ticks, never when empty
    rxempty = 1'b1;
    pulse_tick(6);
    check("R5 empty fifo no timeout", 8'h01);
    rxempty = 1'b0;
    pulse_tick(3);
    check("R5 three ticks", 8'h01);
    pulse_tick(1);
    check("R5 fourth tick", 8'h0C);

    // R12: receive data ranks with timeout, data shown
    rxtrig = 1'b1; step();
    check("R12 data over timeout", 8'h04);
    rxtrig = 1'b0; step();
    check("R12 timeout back", 8'h0C);

    // R6: restart by stop strobe and by holding register read
    rhr_rd = 1'b1; step(); rhr_rd = 1'b0;
    check("R6 rhr read clears timeout", 8'h01);
    pulse_tick(3);
    stopc = 1'b1; step(); stopc = 1'b0;
    pulse_tick(3);
    check("R6 stop strobe restarted count", 8'h01);
    pulse_tick(1);
    check("R6 fires after restart", 8'h0C);
    read_isr();
    check("R4 status read clears timeout", 8'h01);
    rxempty = 1'b1; step();
    check("R5 empty after clear", 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule